// File: doc/BRIEF.md
# Falling Reference Ramp Generator

This block produces a falling digital code that feeds a comparator reference DAC. Software sets a start value, a step size and a mask that says which PWM frame-start sources may launch a ramp. When a frame-start pulse arrives on an enabled source, the block loads the start value. It then lowers the code by the step size on every clock until the code reaches zero. At zero it raises a single-cycle done flag and holds there until the next enabled trigger.

The code only ever moves down. It can rise in one case only: a new trigger loads the start value. If the last step would pass below zero, the code stops at zero, so every ramp ends at the DAC minimum. When a trigger arrives while a ramp is still running, the ramp restarts from the start value.

Top module: `fall_ramp`

## Requirements
- R1: After reset, code_o is 0, active_o is 0 and done_o is 0.
- R2: If any source i has frame_start_i[i] and trig_en_i[i] both high at a clock edge, code_o equals start_val_i after that edge. active_o is then high when start_val_i is nonzero.
- R3: While active_o is high and no enabled trigger is present, code_o drops by step_i at each clock edge. A step_i of 0 acts as a step of 1.
- R4: When step_i is larger than the current code, the next code is 0 and does not wrap.
- R5: On the edge where code_o reaches 0, active_o falls and done_o goes high for exactly one cycle.
- R6: While active_o is low and no enabled trigger is present, code_o keeps its value, and code_o never rises except on a trigger load.
- R7: A frame-start pulse on a source whose trig_en_i bit is 0 has no effect on code_o, active_o or done_o. If all enable bits are 0, the code stays at 0.
- R8: An enabled trigger that arrives while active_o is high reloads start_val_i, and the ramp continues from that value.
- R9: A trigger with start_val_i equal to 0 leaves code_o at 0 and active_o low, and raises done_o for one cycle.
- R10: Several enabled pulses in the same cycle act as one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one ramp step per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_val_i | input | CODE_W | Code loaded on a trigger |
| step_i | input | CODE_W | Amount subtracted per cycle (0 acts as 1) |
| trig_en_i | input | N_SRC | Per-source trigger enable |
| frame_start_i | input | N_SRC | PWM frame-start pulses, one per source |
| code_o | output | CODE_W | DAC reference code |
| active_o | output | 1 | High while the ramp is descending |
| done_o | output | 1 | One-cycle pulse when the code reaches 0 |

## Verification
The hardest case to reach is a restart that lands in the middle of a descent while the step is large enough to saturate on the following cycle. The bench reaches it by launching a ramp, waiting a fixed number of steps, and then firing an enabled pulse. It then runs a ramp with a step larger than the remaining code, so that the reload and the clamp to zero both occur within a few cycles. It also fires pulses on masked sources between ramps and checks that the held zero and the idle flags do not change.

// File: rtl/fall_ramp_pkg.sv
package fall_ramp_pkg;
  localparam int unsigned RAMP_W = 7;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ramp_st_e;
endpackage

// File: rtl/fall_ramp_trig.sv
module fall_ramp_trig #(
  parameter int unsigned N_SRC = 4
) (
  input  logic [N_SRC-1:0] trig_en_i,
  input  logic [N_SRC-1:0] frame_start_i,
  output logic             hit_o
);
  logic [N_SRC-1:0] masked;
  for (genvar g = 0; g < N_SRC; g++) begin : g_mask
    assign masked[g] = trig_en_i[g] & frame_start_i[g];
  end
  assign hit_o = |masked;
endmodule

// File: rtl/fall_ramp_step.sv
module fall_ramp_step #(
  parameter int unsigned CODE_W = 7
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] step_i,
  output logic [CODE_W-1:0] next_o,
  output logic              zero_o
);
  logic [CODE_W-1:0] step_eff;
  always_comb begin
    step_eff = (step_i == '0) ? CODE_W'(1) : step_i;
    next_o   = (code_i > step_eff) ? (code_i - step_eff) : '0;
    zero_o   = (next_o == '0);
  end
endmodule

// File: rtl/fall_ramp_core.sv
module fall_ramp_core
  import fall_ramp_pkg::*;
#(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] start_val_i,
  input  logic [CODE_W-1:0] next_i,
  input  logic              next_zero_i,
  output logic [CODE_W-1:0] code_o,
  output logic              active_o,
  output logic              done_o
);
  ramp_st_e          st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    if (hit_i) begin
      code_d = start_val_i;
      st_d   = (start_val_i == '0) ? ST_DONE : ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          code_d = next_i;
          if (next_zero_i) st_d = ST_DONE;
        end
        ST_DONE: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  assign code_o   = code_q;
  assign active_o = (st_q == ST_RUN);
  assign done_o   = (st_q == ST_DONE);
endmodule

// File: rtl/fall_ramp.sv
module fall_ramp #(
  parameter int unsigned CODE_W = fall_ramp_pkg::RAMP_W,
  parameter int unsigned N_SRC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] start_val_i,
  input  logic [CODE_W-1:0] step_i,
  input  logic [N_SRC-1:0]  trig_en_i,
  input  logic [N_SRC-1:0]  frame_start_i,
  output logic [CODE_W-1:0] code_o,
  output logic              active_o,
  output logic              done_o
);
  logic              hit;
  logic [CODE_W-1:0] next_code;
  logic              next_zero;

  fall_ramp_trig #(.N_SRC(N_SRC)) u_trig (
    .trig_en_i    (trig_en_i),
    .frame_start_i(frame_start_i),
    .hit_o        (hit)
  );

  fall_ramp_step #(.CODE_W(CODE_W)) u_step (
    .code_i(code_o),
    .step_i(step_i),
    .next_o(next_code),
    .zero_o(next_zero)
  );

  fall_ramp_core #(.CODE_W(CODE_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .start_val_i(start_val_i),
    .next_i     (next_code),
    .next_zero_i(next_zero),
    .code_o     (code_o),
    .active_o   (active_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/fall_ramp_chk.sv
module fall_ramp_chk #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned N_SRC  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] start_val_i,
  input logic [N_SRC-1:0]  trig_en_i,
  input logic [N_SRC-1:0]  frame_start_i,
  input logic [CODE_W-1:0] code_o,
  input logic              active_o,
  input logic              done_o
);
  logic trig;
  assign trig = |(trig_en_i & frame_start_i);

  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> code_o == $past(start_val_i)); // R2
  AST_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig |=> code_o <= $past(code_o)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !trig) |=> $stable(code_o)); // R6
  AST_DONE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (code_o == '0 && !active_o)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trig) |=> !done_o); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> code_o == '0); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && done_o)); // R5
endmodule

bind fall_ramp fall_ramp_chk #(.CODE_W(CODE_W), .N_SRC(N_SRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_val_i  (start_val_i),
  .trig_en_i    (trig_en_i),
  .frame_start_i(frame_start_i),
  .code_o       (code_o),
  .active_o     (active_o),
  .done_o       (done_o)
);

// File: tb/fall_ramp_tb.sv
module fall_ramp_tb;
  localparam int CW = 7;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] start_val = '0;
  logic [CW-1:0] step = '0;
  logic [NS-1:0] trig_en = '0;
  logic [NS-1:0] frame_start = '0;
  logic [CW-1:0] code;
  logic          active;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fall_ramp #(.CODE_W(CW), .N_SRC(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_val_i(start_val), .step_i(step),
    .trig_en_i(trig_en), .frame_start_i(frame_start),
    .code_o(code), .active_o(active), .done_o(done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(string req, int c, int a, int d);
    chk({req, " code"}, int'(code), c);
    chk({req, " active"}, int'(active), a);
    chk({req, " done"}, int'(done), d);
  endtask

  // fires pulse mask, then follows the ramp down to zero and one idle cycle
  task automatic run_ramp(string req, int sv, int st, logic [NS-1:0] pulse);
    int exp;
    int eff;
    start_val = CW'(sv);
    step = CW'(st);
    frame_start = pulse;
    tick();
    frame_start = '0;
    exp = sv;
    chk_state({req, " load"}, exp, (exp != 0), (exp == 0));
    eff = (st == 0) ? 1 : st;
    while (exp != 0) begin
      tick();
      exp = (exp > eff) ? exp - eff : 0;
      chk_state({req, " step"}, exp, (exp != 0), (exp == 0));
    end
    tick();
    chk_state({req, " hold"}, 0, 0, 0);
  endtask

  task automatic t_reset();
    #1;
    chk_state("R1 reset", 0, 0, 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk_state("R1 after release", 0, 0, 0);
  endtask

  task automatic t_no_enable();
    trig_en = '0;
    start_val = 7'd90;
    step = 7'd3;
    for (int i = 0; i < 4; i++) begin
      frame_start = NS'(1) << i;
      tick();
      chk_state("R7 all disabled", 0, 0, 0);
    end
    frame_start = '0;
  endtask

  task automatic t_masked_src();
    trig_en = 4'b0101;
    start_val = 7'd50;
    frame_start = 4'b1010;
    tick();
    frame_start = '0;
    chk_state("R7 masked source", 0, 0, 0);
    tick();
    chk_state("R7 masked source later", 0, 0, 0);
  endtask

  task automatic t_restart();
    int exp;
    trig_en = 4'b0010;
    start_val = 7'd100;
    step = 7'd10;
    frame_start = 4'b0010;
    tick();
    frame_start = '0;
    chk_state("R2 load 100", 100, 1, 0);
    for (int i = 1; i <= 3; i++) begin
      tick();
      chk_state("R3 pre-restart", 100 - 10 * i, 1, 0);
    end
    start_val = 7'd60;
    step = 7'd25;
    frame_start = 4'b0010;
    tick();
    frame_start = '0;
    chk_state("R8 restart", 60, 1, 0);
    tick();
    chk_state("R8 continue", 35, 1, 0);
    tick();
    chk_state("R4 step", 10, 1, 0);
    tick();
    chk_state("R4 saturate", 0, 0, 1);
    tick();
    chk_state("R5 done single", 0, 0, 0);
    // masked pulse while idle at zero must change nothing
    frame_start = 4'b0001;
    tick();
    frame_start = '0;
    chk_state("R7 idle masked", 0, 0, 0);
    exp = 0;
    chk("R6 hold zero", int'(code), exp);
  endtask

  task automatic t_zero_start();
    trig_en = 4'b1000;
    start_val = '0;
    frame_start = 4'b1000;
    tick();
    frame_start = '0;
    chk_state("R9 zero start", 0, 0, 1);
    tick();
    chk_state("R9 zero start after", 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_no_enable();
    t_masked_src();
    trig_en = 4'b0001;
    run_ramp("R3 basic 100/7", 100, 7, 4'b0001);
    trig_en = 4'b0100;
    run_ramp("R3 step zero as one", 5, 0, 4'b0100);
    trig_en = 4'b1111;
    run_ramp("R10 multi pulse", 127, 40, 4'b1111);
    trig_en = 4'b0001;
    run_ramp("R4 step above start", 9, 127, 4'b0001);
    run_ramp("R5 exact end", 12, 4, 4'b0001);
    t_restart();
    t_zero_start();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule